// File: doc/BRIEF.md
# Dithered Sine Synthesizer for a 4-bit Ladder DAC

This block is a direct digital synthesizer meant to feed a 4-bit resistor-ladder DAC through double-data-rate output registers. A wide phase register adds a tuning word on every system clock. The top four bits of that phase select one of sixteen amplitude codes from a full-period sine table. Each amplitude code is 5 bits wide, but the DAC takes only 4 bits. The block therefore splits every 5-bit code into two 4-bit words, one for the rising edge and one for the falling edge of the clock. Averaged over the clock period, the pair keeps the fifth bit of resolution.

With a 48-bit phase and a 100 MHz system clock, the tuning word sets the output frequency in steps far below one hertz. A word near 0.27 × 2^48 places the tone close to 27 MHz, and small changes to it trim the tone by about a percent either way. The analog ladder, the resonant filter and the comparator that follow the DAC are outside this block.

Top module: `dds_dither_sine`

## Requirements
- R1: While reset is high, both output words are mid-scale (8) and the phase is cleared. The first pair after reset is taken from phase zero.
- R2: On every clock edge without reset, the phase grows by the tuning word, modulo 2^48.
- R3: The amplitude code is read from the table through the top 4 phase bits. Index 0 to 15 gives 15, 21, 26, 29, 30, 29, 26, 21, 15, 9, 4, 1, 0, 1, 4, 9. The codes are offset binary and never exceed 30.
- R4: The rising-edge word equals the code divided by 2, rounded down. The falling-edge word equals the code divided by 2, rounded up. The falling word is never below the rising word and never more than one above it, and the two words sum to the code.
- R5: Both words are registered and change together on the clock edge. The pair visible after edge n comes from the phase held before edge n.
- R6: A tuning word of zero freezes the phase, so both output words stay constant.
- R7: A new tuning word takes effect on the next clock edge and does not restart the phase.
- R8: A tuning word at or above 2^47 moves the phase backwards through the table, wrapping through zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 48 | Phase increment added per clock |
| dac_word_rise | output | 4 | Sample for the rising half-cycle (code rounded down) |
| dac_word_fall | output | 4 | Sample for the falling half-cycle (code rounded up) |

## Verification
A wrong phase value appears at the ports one clock later, as an output pair that does not match the table entry expected for that cycle. A wrong increment or a lost carry below the index bits can stay hidden for many cycles, until the error reaches bit 44. The bench therefore uses tuning words that step the index once per clock, and also tuning words whose carries cross the lower bits. A wrong table entry or a wrong split between the two words shows as soon as that index is reached, and a sweep touches every index within sixteen clocks.

// File: rtl/dds_pkg.sv
package dds_pkg;
   localparam int TBL_IDX_W = 4;
   localparam int TBL_AMP_W = 5;

   // Full sine period in 16 equal steps, offset binary centred on 15, peak 30
   function automatic logic [TBL_AMP_W-1:0] sine_code(input logic [TBL_IDX_W-1:0] idx);
      logic [TBL_AMP_W-1:0] v;
      case (idx)
         4'd0:  v = 5'd15;
         4'd1:  v = 5'd21;
         4'd2:  v = 5'd26;
         4'd3:  v = 5'd29;
         4'd4:  v = 5'd30;
         4'd5:  v = 5'd29;
         4'd6:  v = 5'd26;
         4'd7:  v = 5'd21;
         4'd8:  v = 5'd15;
         4'd9:  v = 5'd9;
         4'd10: v = 5'd4;
         4'd11: v = 5'd1;
         4'd12: v = 5'd0;
         4'd13: v = 5'd1;
         4'd14: v = 5'd4;
         default: v = 5'd9;
      endcase
      return v;
   endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 48,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] step,
   output logic [IDX_W-1:0] phase_idx
);
   localparam int IDX_LSB = ACC_W - IDX_W;

   logic [ACC_W-1:0] phase_q;
   logic             live_q;

   generate
      if (IDX_W >= ACC_W) begin : g_bad_width
         $error("dds_phase_acc: index must be narrower than accumulator");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
         live_q  <= 1'b0;
      end else begin
         phase_q <= phase_q + step;
         live_q  <= 1'b1;
      end
   end

   assign phase_idx = phase_q[ACC_W-1:IDX_LSB];

   // R2: phase advances by the previous increment
   p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
      live_q |-> (phase_q == $past(phase_q) + $past(step)));
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
   parameter int IDX_W = 4,
   parameter int AMP_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   output logic [AMP_W-1:0] amp
);
   generate
      if (IDX_W != dds_pkg::TBL_IDX_W || AMP_W != dds_pkg::TBL_AMP_W) begin : g_bad_table
         $error("dds_sine_rom: table is defined for 16 entries of 5 bits");
      end
   endgenerate

   always_comb amp = dds_pkg::sine_code(idx);
endmodule

// File: rtl/dds_dither_split.sv
module dds_dither_split #(
   parameter int AMP_W     = 5,
   parameter bit DITHER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [AMP_W-1:0] amp,
   output logic [AMP_W-2:0] word_lo,
   output logic [AMP_W-2:0] word_hi
);
   localparam int OUT_W = AMP_W - 1;
   localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

   logic [AMP_W-1:0] amp_up;
   logic [OUT_W-1:0] next_hi;
   logic             live_q;

   generate
      if (AMP_W < 2) begin : g_bad_amp
         $error("dds_dither_split: amplitude needs at least 2 bits");
      end
      if (DITHER_EN) begin : g_dither
         assign amp_up  = amp + AMP_W'(1);
         assign next_hi = amp_up[AMP_W-1:1];
      end else begin : g_trunc
         assign amp_up  = amp;
         assign next_hi = amp[AMP_W-1:1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         word_lo <= MID;
         word_hi <= MID;
         live_q  <= 1'b0;
      end else begin
         word_lo <= amp[AMP_W-1:1];
         word_hi <= next_hi;
         live_q  <= 1'b1;
      end
   end

   // R4: falling word equals rising word or one above it
   p_pair_gap_r4: assert property (@(posedge clk) disable iff (rst)
      (word_hi == word_lo) || (word_hi == word_lo + OUT_W'(1)));

   generate
      if (DITHER_EN) begin : g_sum_chk
         // R4: the pair sums to the code seen one cycle earlier
         p_pair_sum_r4: assert property (@(posedge clk) disable iff (rst)
            live_q |-> ({1'b0, word_lo} + {1'b0, word_hi} == $past(amp)));
      end
   endgenerate
endmodule

// File: rtl/dds_dither_sine.sv
module dds_dither_sine #(
   parameter int ACC_W     = 48,
   parameter int IDX_W     = 4,
   parameter int AMP_W     = 5,
   parameter bit DITHER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] tune_word,
   output logic [AMP_W-2:0] dac_word_rise,
   output logic [AMP_W-2:0] dac_word_fall
);
   logic [IDX_W-1:0] idx;
   logic [AMP_W-1:0] amp;
   logic [1:0]       age_q;

   dds_phase_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_acc (
      .clk(clk), .rst(rst), .step(tune_word), .phase_idx(idx));

   dds_sine_rom #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_rom (
      .idx(idx), .amp(amp));

   dds_dither_split #(.AMP_W(AMP_W), .DITHER_EN(DITHER_EN)) u_split (
      .clk(clk), .rst(rst), .amp(amp),
      .word_lo(dac_word_rise), .word_hi(dac_word_fall));

   always_ff @(posedge clk) begin
      if (rst)             age_q <= 2'd0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   // R6: a zero increment two cycles back leaves the output pair unchanged
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (age_q >= 2'd2 && $past(tune_word, 2) == '0) |->
         ($stable(dac_word_rise) && $stable(dac_word_fall)));
endmodule

// File: tb/sim_dds_dither_sine.sv
module sim_dds_dither_sine;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [47:0] tw  = '0;
   logic [3:0]  rise_w, fall_w;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit timeout = 1'b0;

   always #2.5 clk = ~clk;

   dds_dither_sine u0 (.clk(clk), .rst(rst), .tune_word(tw),
                       .dac_word_rise(rise_w), .dac_word_fall(fall_w));

   // Table from R3
   function automatic logic [4:0] ref_code(input logic [3:0] i);
      logic [4:0] t [16] = '{5'd15, 5'd21, 5'd26, 5'd29, 5'd30, 5'd29, 5'd26, 5'd21,
                             5'd15, 5'd9,  5'd4,  5'd1,  5'd0,  5'd1,  5'd4,  5'd9};
      return t[i];
   endfunction

   // Reference from R1, R2, R4, R5
   logic [47:0] m_phase = '0;
   logic [3:0]  exp_r = 4'd8, exp_f = 4'd8;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst) begin
         m_phase <= '0;
         exp_r   <= 4'd8;
         exp_f   <= 4'd8;
      end else begin
         exp_r   <= ref_code(m_phase[47:44]) >> 1;
         exp_f   <= 4'((5'(ref_code(m_phase[47:44])) + 5'd1) >> 1);
         m_phase <= m_phase + tw;
      end
   end

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic run(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(req, rise_w, exp_r);
         chk(req, fall_w, exp_f);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1; tw = 48'h1000_0000_0000;
      repeat (3) @(negedge clk);
      chk("R1 rise mid", rise_w, 4'd8);
      chk("R1 fall mid", fall_w, 4'd8);
      rst = 1'b0;
      @(negedge clk);
      // first pair from phase 0: code 15 -> 7 and 8
      chk("R1 first rise", rise_w, 4'd7);
      chk("R1 first fall", fall_w, 4'd8);
   endtask

   task automatic t_sweep;
      // 2^44 steps one table entry per clock: covers R3 and R4, R5
      run(34, "R3/R4/R5 sweep");
   endtask

   task automatic t_hold;
      logic [3:0] r0, f0;
      tw = 48'h0;
      @(negedge clk);
      @(negedge clk);
      r0 = rise_w; f0 = fall_w;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R6 rise held", rise_w, r0);
         chk("R6 fall held", fall_w, f0);
      end
   endtask

   task automatic t_fine;
      tw = 48'h451E_B851_EB85;
      run(200, "R2 near 27MHz");
      tw = 48'h0000_0FFF_FFFF_FFFF >> 4;
      run(100, "R2 low carry");
   endtask

   task automatic t_retune;
      tw = 48'h3000_0000_0000;
      run(5, "R7 step3");
      tw = 48'h1000_0000_0000;
      run(5, "R7 step1");
   endtask

   task automatic t_back;
      tw = 48'hF000_0000_0000;
      run(20, "R8 backwards");
      tw = 48'h8000_0000_0001;
      run(20, "R8 half step");
   endtask

   initial begin
      fork
         begin
            t_reset;
            t_sweep;
            t_hold;
            t_fine;
            t_retune;
            t_back;
            t_reset;
            run(10, "R1 after reset");
         end
         begin
            while (cyc < 20000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      if (timeout) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule